// File: doc/BRIEF.md
# Boot Patch Loader with Fetch-Address Trap

After reset this block runs a short hardware sequence. It reads a patch descriptor from a byte-wide nonvolatile memory through a request/valid read port with variable latency. The first byte is a patch length. The next three bytes form a 24-bit trap address. The patch code that follows is copied byte by byte into on-chip RAM. The trap comparator is armed only once that copy is finished. If the length byte is zero, the sequence ends at once and the trap stays off.

Once armed, the comparator watches the CPU instruction-fetch address. A qualified fetch of the trap address sets a sticky hit flag, and the flag raises an interrupt request. The CPU's handler then branches to the RAM copy of the patch. The handler, the CPU, the interrupt controller and the memory device all live outside this block.

Software can rewrite the trap address and the enable bit, and it can clear the hit flag. These software writes take effect only after the boot sequence has completed.

Top module: `boot_patch_trap`

## Requirements
- R1: When nonvolatile byte 0x0000 (the patch length) reads as zero, only that one byte is read, no RAM write occurs, `boot_done` rises, and `trap_en` stays 0, so a fetch of any address sets no flag.
- R2: Nonvolatile bytes 0x0001, 0x0002 and 0x0003 are loaded into `trap_addr` as bits [7:0], [15:8] and [23:16] respectively.
- R3: With a length N greater than zero, the patch bytes are read from nonvolatile addresses 0x0010+i for i = 0..N-1, in ascending order. The read order is the length byte, then 0x0001, 0x0002, 0x0003, then the patch bytes.
- R4: Each patch byte i is written to RAM address 0x000400+i with the value read from the memory. Exactly N writes occur, in ascending order.
- R5: While `nv_req` is high and `nv_valid` is low, `nv_addr` holds steady. Exactly one byte is consumed for each cycle in which `nv_req` and `nv_valid` are both high.
- R6: `trap_en` is 0 until `boot_done` is 1. After a boot with nonzero length, `trap_en` reads 1.
- R7: The hit flag `trap_hit` is set on the cycle after one in which `fetch_valid` is 1, `trap_en` is 1 and all 24 bits of `fetch_addr` equal `trap_addr`. A mismatch in any bit, or `fetch_valid` low, leaves the flag clear.
- R8: `trap_hit` stays set until software clears it by writing a control word with bit 1 = 1. A new hit in the same cycle as a clear leaves the flag set.
- R9: `irq` is 1 exactly when `trap_hit` is 1 and `trap_en` is 1.
- R10: The software write port works as follows. With `sw_sel`=0, a write is a control write: bit 0 sets `trap_en` and bit 1 clears the hit flag. With `sw_sel`=1, a write loads `trap_addr` from `sw_wdata`. Software writes have no effect while `boot_done` is 0.
- R11: While reset is held, `boot_done`, `trap_en`, `trap_hit`, `irq` and `ram_we` are 0, and `trap_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nv_req | output | 1 | Nonvolatile read request, held until valid |
| nv_addr | output | 16 | Nonvolatile byte address |
| nv_valid | input | 1 | Read data valid |
| nv_data | input | 8 | Read data byte |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 24 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| fetch_valid | input | 1 | Instruction-fetch qualifier |
| fetch_addr | input | 24 | Instruction-fetch address |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0: control word, 1: trap address |
| sw_wdata | input | 24 | Software write data |
| boot_done | output | 1 | Boot sequence finished |
| trap_en | output | 1 | Comparator enable |
| trap_hit | output | 1 | Sticky hit flag |
| trap_addr | output | 24 | Trap address register |
| irq | output | 1 | Interrupt request |

## Verification
The bench covers a zero length byte. A design that mishandled it would go on to read the address bytes, write RAM, or arm the trap. It also covers lengths of 1 and 0x80 under memory latencies from zero to several cycles. These expose an off-by-one copy, which leaves the last byte out or adds a stray write, and any advance on a stale or missing valid. Near-miss fetch addresses, including a difference only in bit 23 and a fetch with its qualifier low, catch a narrow or unqualified comparator. A clear written in the same cycle as a new hit catches a design that drops a real trap. Software writes issued in the middle of boot would corrupt the loaded address or arm the trap early if they were not blocked.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int ADDR_W = 24;
  localparam int NVA_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_LEN, ST_A0, ST_A1, ST_A2, ST_COPY, ST_DONE
  } ld_state_t;

  // nonvolatile address of patch byte idx
  function automatic logic [NVA_W-1:0] code_src(input logic [NVA_W-1:0] base,
                                                input logic [BYTE_W-1:0] idx);
    return base + NVA_W'(idx);
  endfunction

  // RAM address of patch byte idx
  function automatic logic [ADDR_W-1:0] code_dst(input logic [ADDR_W-1:0] base,
                                                 input logic [BYTE_W-1:0] idx);
    return base + ADDR_W'(idx);
  endfunction

  function automatic logic addr_equal(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] b);
    return (a ^ b) == '0;
  endfunction
endpackage

// File: rtl/bpt_loader.sv
module bpt_loader
  import bpt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE  = 24'h000400,
  parameter logic [NVA_W-1:0]  CODE_BASE = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              nv_req,
  output logic [NVA_W-1:0]  nv_addr,
  input  logic              nv_valid,
  input  logic [BYTE_W-1:0] nv_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic [2:0]        addr_ld,
  output logic [BYTE_W-1:0] addr_byte,
  output logic              arm,
  output logic              done
);
  ld_state_t         st_q;
  logic [BYTE_W-1:0] len_q, idx_q;
  logic              take, last_byte;

  assign nv_req    = (st_q != ST_DONE);
  assign take      = nv_req && nv_valid;
  assign last_byte = (idx_q == len_q - 1'b1);
  assign done      = (st_q == ST_DONE);

  always_comb begin
    case (st_q)
      ST_A0:   nv_addr = NVA_W'(1);
      ST_A1:   nv_addr = NVA_W'(2);
      ST_A2:   nv_addr = NVA_W'(3);
      ST_COPY: nv_addr = code_src(CODE_BASE, idx_q);
      default: nv_addr = '0;
    endcase
  end

  assign ram_we    = take && (st_q == ST_COPY);
  assign ram_addr  = code_dst(RAM_BASE, idx_q);
  assign ram_wdata = nv_data;
  assign addr_ld   = {take && (st_q == ST_A2), take && (st_q == ST_A1),
                      take && (st_q == ST_A0)};
  assign addr_byte = nv_data;
  assign arm       = ram_we && last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_LEN;
      len_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      case (st_q)
        ST_LEN: begin
          len_q <= nv_data;
          st_q  <= (nv_data == '0) ? ST_DONE : ST_A0;
        end
        ST_A0: st_q <= ST_A1;
        ST_A1: st_q <= ST_A2;
        ST_A2: st_q <= ST_COPY;
        ST_COPY: begin
          idx_q <= idx_q + 1'b1;
          if (last_byte) st_q <= ST_DONE;
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end

  // R5
  nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && !nv_valid) |=> (nv_req && $stable(nv_addr)));

  // R4
  ram_we_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (nv_valid && !done));

  // R1
  done_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !nv_req));
endmodule

// File: rtl/bpt_matcher.sv
module bpt_matcher
  import bpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] target,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              clr,
  output logic              hit,
  output logic              flag,
  output logic              irq
);
  logic flag_q;

  assign hit  = en && fetch_valid && addr_equal(fetch_addr, target);
  assign flag = flag_q;
  assign irq  = flag_q && en;

  always_ff @(posedge clk) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  // R7
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R9
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && flag_q));
endmodule

// File: rtl/boot_patch_trap.sv
module boot_patch_trap
  import bpt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RAM_BASE  = 24'h000400,
  parameter logic [NVA_W-1:0]  CODE_BASE = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              nv_req,
  output logic [NVA_W-1:0]  nv_addr,
  input  logic              nv_valid,
  input  logic [BYTE_W-1:0] nv_data,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              sw_wr,
  input  logic              sw_sel,
  input  logic [ADDR_W-1:0] sw_wdata,
  output logic              boot_done,
  output logic              trap_en,
  output logic              trap_hit,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              irq
);
  logic [2:0]        addr_ld;
  logic [BYTE_W-1:0] addr_byte;
  logic              arm, sw_ctrl, sw_tgt, sw_clr, hit;
  logic [ADDR_W-1:0] tgt_q;
  logic              en_q;

  bpt_loader #(.RAM_BASE(RAM_BASE), .CODE_BASE(CODE_BASE)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .nv_req(nv_req), .nv_addr(nv_addr), .nv_valid(nv_valid), .nv_data(nv_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .addr_ld(addr_ld), .addr_byte(addr_byte), .arm(arm), .done(boot_done)
  );

  assign sw_ctrl = boot_done && sw_wr && !sw_sel;
  assign sw_tgt  = boot_done && sw_wr && sw_sel;
  assign sw_clr  = sw_ctrl && sw_wdata[1];

  generate
    for (genvar b = 0; b < 3; b++) begin : g_tgt_byte
      always_ff @(posedge clk) begin
        if (!rst_n)          tgt_q[b*BYTE_W +: BYTE_W] <= '0;
        else if (addr_ld[b]) tgt_q[b*BYTE_W +: BYTE_W] <= addr_byte;
        else if (sw_tgt)     tgt_q[b*BYTE_W +: BYTE_W] <= sw_wdata[b*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (arm)     en_q <= 1'b1;
    else if (sw_ctrl) en_q <= sw_wdata[0];
  end

  bpt_matcher u_match (
    .clk(clk), .rst_n(rst_n), .en(en_q), .target(tgt_q),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .clr(sw_clr),
    .hit(hit), .flag(trap_hit), .irq(irq)
  );

  assign trap_en   = en_q;
  assign trap_addr = tgt_q;

  // R6
  arm_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_en |-> boot_done);

  // R6
  arm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (trap_en && boot_done));

  // R10
  sw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_done && addr_ld == '0) |=> $stable(trap_addr));
endmodule

// File: tb/test_boot_patch_trap.sv
`timescale 1ns/1ps
module test_boot_patch_trap;
  logic        clk = 0, rst_n = 0;
  logic        nv_req, nv_valid = 0;
  logic [15:0] nv_addr;
  logic [7:0]  nv_data = 0;
  logic        ram_we;
  logic [23:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        fetch_valid = 0, sw_wr = 0, sw_sel = 0;
  logic [23:0] fetch_addr = 0, sw_wdata = 0;
  logic        boot_done, trap_en, trap_hit, irq;
  logic [23:0] trap_addr;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0]  nvm [0:511];
  logic [7:0]  ram_log [0:255];
  logic [23:0] ram_alog [0:255];
  logic [15:0] rd_log [0:300];
  int n_wr = 0, n_rd = 0, lat = 0, wcnt = 0, hold_bad = 0, early_arm = 0;
  logic [15:0] held;

  boot_patch_trap i_boot_patch_trap (.*);

  always #4 clk = ~clk;

  // nonvolatile memory model: answers after lat waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      nv_valid = 0; wcnt = 0;
    end else if (nv_valid) begin
      nv_valid = 0; wcnt = 0;
    end else if (nv_req) begin
      if (wcnt == 0) held = nv_addr;
      else if (nv_addr != held) hold_bad++;
      if (wcnt >= lat) begin
        nv_valid = 1; nv_data = nvm[nv_addr[8:0]];
      end else wcnt++;
    end
    if (rst_n && trap_en && !boot_done) early_arm++;
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && nv_req && nv_valid && n_rd < 300) begin rd_log[n_rd] = nv_addr; n_rd++; end
    if (rst_n && ram_we && n_wr < 256) begin
      ram_log[n_wr] = ram_wdata; ram_alog[n_wr] = ram_addr; n_wr++;
    end
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic boot(input int len, input logic [23:0] ta, input int l);
    for (int i = 0; i < 512; i++) nvm[i] = 8'(i * 13 + len + 5);
    nvm[0] = 8'(len); nvm[1] = ta[7:0]; nvm[2] = ta[15:8]; nvm[3] = ta[23:16];
    lat = l;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    n_wr = 0; n_rd = 0; hold_bad = 0; early_arm = 0;
    rst_n = 1;
    for (int k = 0; k < 3000 && !boot_done; k++) @(negedge clk);
  endtask

  task automatic fetch(input logic [23:0] a, input logic v);
    fetch_addr = a; fetch_valid = v;
    @(negedge clk);
    fetch_valid = 0;
  endtask

  task automatic sw(input logic sel, input logic [23:0] d);
    sw_sel = sel; sw_wdata = d; sw_wr = 1;
    @(negedge clk);
    sw_wr = 0;
  endtask

  task automatic t_reset;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R11 done", boot_done, 0); chk("R11 en", trap_en, 0);
    chk("R11 hit", trap_hit, 0);   chk("R11 irq", irq, 0);
    chk("R11 we", ram_we, 0);      chk("R11 addr", trap_addr, 0);
  endtask

  task automatic t_zero;
    boot(0, 24'h000000, 2);
    chk("R1 done", boot_done, 1);
    chk("R1 reads", n_rd, 1);
    chk("R1 writes", n_wr, 0);
    chk("R1 en", trap_en, 0);
    fetch(24'h000000, 1);
    chk("R1 no hit", trap_hit, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_load(input int len, input logic [23:0] ta, input int l);
    int bad_rd, bad_wr;
    boot(len, ta, l);
    bad_rd = 0; bad_wr = 0;
    chk("R2 addr", trap_addr, ta);
    chk("R3 reads", n_rd, len + 4);
    for (int i = 0; i < 4; i++) if (rd_log[i] != 16'(i)) bad_rd++;
    for (int i = 0; i < len; i++) if (rd_log[i+4] != 16'(16'h0010 + i)) bad_rd++;
    chk("R3 order", bad_rd, 0);
    chk("R4 count", n_wr, len);
    for (int i = 0; i < len; i++)
      if (ram_alog[i] != 24'h000400 + 24'(i) || ram_log[i] != nvm[16 + i]) bad_wr++;
    chk("R4 data", bad_wr, 0);
    chk("R5 hold", hold_bad, 0);
    chk("R6 early", early_arm, 0);
    chk("R6 en", trap_en, 1);
  endtask

  task automatic t_match;
    t_load(5, 24'hFF8050, 0);
    fetch(24'hFF8051, 1);  chk("R7 bit0 miss", trap_hit, 0);
    fetch(24'h7F8050, 1);  chk("R7 bit23 miss", trap_hit, 0);
    fetch(24'hFF8050, 0);  chk("R7 unqualified", trap_hit, 0);
    fetch(24'hFF8050, 1);  chk("R7 hit", trap_hit, 1);
    chk("R9 irq", irq, 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", trap_hit, 1);
    sw(0, 24'h3);
    chk("R8 cleared", trap_hit, 0); chk("R10 en kept", trap_en, 1);
    chk("R9 irq off", irq, 0);
    // clear coinciding with hit
    fetch_addr = 24'hFF8050; fetch_valid = 1;
    sw(0, 24'h3);
    fetch_valid = 0;
    chk("R8 set wins", trap_hit, 1);
  endtask

  task automatic t_sw;
    // flag is set from t_match; disable without clearing
    sw(0, 24'h0);
    chk("R9 irq masked", irq, 0); chk("R9 flag kept", trap_hit, 1);
    sw(0, 24'h1);
    chk("R9 irq back", irq, 1);
    sw(0, 24'h2);
    chk("R10 disabled", trap_en, 0);
    sw(1, 24'h000ABC);
    chk("R10 addr write", trap_addr, 24'h000ABC);
    fetch(24'h000ABC, 1);
    chk("R10 no hit when off", trap_hit, 0);
    sw(0, 24'h1);
    fetch(24'h000ABC, 1);
    chk("R10 hit new addr", trap_hit, 1);
  endtask

  task automatic t_boot_ignore;
    for (int i = 0; i < 512; i++) nvm[i] = 8'(i * 3 + 1);
    nvm[0] = 8'd1; nvm[1] = 8'h56; nvm[2] = 8'h34; nvm[3] = 8'h12;
    lat = 6;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    early_arm = 0; rst_n = 1;
    repeat (3) @(negedge clk);
    sw(1, 24'h111111);
    sw(0, 24'h1);
    chk("R10 en blocked", trap_en, 0);
    for (int k = 0; k < 3000 && !boot_done; k++) @(negedge clk);
    chk("R10 addr kept", trap_addr, 24'h123456);
    chk("R6 early", early_arm, 0);
  endtask

  initial begin
    t_reset;
    t_zero;
    t_load(1, 24'h123456, 3);
    t_load(8'h80, 24'hFF8050, 1);
    t_match;
    t_sw;
    t_boot_ignore;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule